// File: doc/BRIEF.md
# Counter-Driven Response Signature Analyzer

This block is a self-test engine. It steps a binary pattern counter through a fixed number of test patterns, presents each pattern on a bus to a unit under test, and takes one response bit back per pattern. The bit arrives with a valid strobe. The response stream feeds two compactors in parallel. One counts logic changes on the response line. The other shifts every response bit into a 16-bit linear feedback shift register.

After the last response has been taken in, the engine compares the final register contents with a known-good signature. That signature comes from a small constant table, and the entry is picked when the run starts. The engine then pulses a completion flag and raises either pass or fail. The signature can be read in full, or one hexadecimal digit at a time, with the most significant digit first.

Top module: `sig_analyzer_bist`

## Requirements
- R1: When `start_i` is high while the engine is idle, a run begins at the next edge. After that edge, `busy_o` is 1, `pat_o` is 0, and the `ref_sel_i` value seen at that edge is kept for the whole run.
- R2: During a run, `pat_o` rises by exactly one on each edge where `rsp_vld_i` is high. It holds its value on edges where `rsp_vld_i` is low. The patterns therefore go out in ascending order, from 0 to NUM_PAT-1.
- R3: The transition count `trans_o` is cleared at start. The first accepted response bit only loads the previous-bit register. After that, every accepted bit that differs from the previous accepted bit adds one, whether the change is rising or falling.
- R4: `sig_o` is cleared at start. On each accepted bit b it becomes `{sig[14:0], sig[15]^sig[11]^sig[8]^sig[6]^b}`. These taps implement x^16+x^12+x^9+x^7+1.
- R5: `digit_o` shows one nibble of `sig_o`. Digit select 0 gives bits 15:12, 1 gives bits 11:8, 2 gives bits 7:4 and 3 gives bits 3:0.
- R6: At the end of a run, `pass_o` is set if `sig_o` equals table entry k of `GOLD_TAB` (bits 16k+15:16k), where k is the latched select. Otherwise `fail_o` is set. The two are never high together.
- R7: `done_o` is a one-cycle pulse. It is high during the cycle that follows the edge after the edge that accepted the last response. `busy_o` drops at the same edge where `done_o` rises.
- R8: `pass_o` and `fail_o` keep their values from the done pulse until the next accepted start, which clears them both.
- R9: A start request during a run has no effect. The pattern count, the transition count and the signature continue as if no start request had arrived.
- R10: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o`, `pat_o`, `trans_o` and `sig_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request; acted on only when idle |
| ref_sel_i | input | $clog2(NUM_REF) | Selects the good-signature table entry, latched at start |
| rsp_bit_i | input | 1 | Serial response bit from the unit under test |
| rsp_vld_i | input | 1 | Response bit valid strobe |
| digit_sel_i | input | 2 | Hex digit select, 0 = most significant |
| pat_o | output | $clog2(NUM_PAT) | Current test pattern |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Signature matched the selected entry |
| fail_o | output | 1 | Signature did not match |
| sig_o | output | 16 | Signature register |
| trans_o | output | $clog2(NUM_PAT) | Transition count |
| digit_o | output | 4 | Selected hex digit of the signature |

## Verification
The bench works to a fixed timing for each result.
- **Pattern:** the pattern for index i must be on `pat_o` in the half cycle after the edge that accepted response i-1. The bench checks it there, before it drives the next response.
- **Signature and transition count:** both are final one edge after the last accepted bit. They are compared with the bench's own model one further edge later, in the half cycle where `done_o` is high.
- **Pass and fail:** these are checked in that same half cycle.
- **Done pulse and held results:** the bench confirms that `done_o` is low in the half cycle before the pulse and in the one after it. It also confirms that the pass/fail verdict still holds several idle cycles later.

// File: rtl/sig_analyzer_bist.sv
module sig_analyzer_bist #(
  parameter int NUM_PAT = 64,
  parameter int NUM_REF = 4,
  parameter logic [16*NUM_REF-1:0] GOLD_TAB = {16'h1D0F, 16'h7A31, 16'hC4E2, 16'h0B5A}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [$clog2(NUM_REF)-1:0] ref_sel_i,
  input  logic                       rsp_bit_i,
  input  logic                       rsp_vld_i,
  input  logic [1:0]                 digit_sel_i,
  output logic [$clog2(NUM_PAT)-1:0] pat_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       pass_o,
  output logic                       fail_o,
  output logic [15:0]                sig_o,
  output logic [$clog2(NUM_PAT)-1:0] trans_o,
  output logic [3:0]                 digit_o
);
  localparam int PW = $clog2(NUM_PAT);
  localparam int RW = $clog2(NUM_REF);
  localparam logic [PW-1:0] LAST = PW'(NUM_PAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t         state;
  logic           first_q, prev_q;
  logic [RW-1:0]  sel_q;
  logic [15:0]    sig_nx, gold_w;

  assign sig_nx  = {sig_o[14:0], sig_o[15] ^ sig_o[11] ^ sig_o[8] ^ sig_o[6] ^ rsp_bit_i};
  assign gold_w  = GOLD_TAB[{sel_q, 4'b0000} +: 16];
  assign digit_o = sig_o[{~digit_sel_i, 2'b00} +: 4];
  assign busy_o  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pat_o   <= '0;
      trans_o <= '0;
      sig_o   <= '0;
      first_q <= 1'b0;
      prev_q  <= 1'b0;
      sel_q   <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          state   <= S_RUN;
          pat_o   <= '0;
          trans_o <= '0;
          sig_o   <= '0;
          first_q <= 1'b1;
          sel_q   <= ref_sel_i;
          pass_o  <= 1'b0;
          fail_o  <= 1'b0;
        end
        S_RUN: if (rsp_vld_i) begin
          sig_o   <= sig_nx;
          prev_q  <= rsp_bit_i;
          first_q <= 1'b0;
          if (!first_q && (rsp_bit_i != prev_q)) trans_o <= trans_o + 1'b1;
          if (pat_o == LAST) state <= S_FIN;
          else               pat_o <= pat_o + 1'b1;
        end
        default: begin
          state  <= S_IDLE;
          done_o <= 1'b1;
          pass_o <= (sig_o == gold_w);
          fail_o <= (sig_o != gold_w);
        end
      endcase
    end
  end

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i) |=> (busy_o && pat_o == '0 && sig_o == '0 && trans_o == '0));
  assert_pat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && rsp_vld_i && pat_o != LAST) |=> (pat_o == $past(pat_o) + 1'b1));
  assert_pat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !rsp_vld_i) |=> $stable(pat_o));
  assert_no_count_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && rsp_vld_i && (first_q || rsp_bit_i == prev_q)) |=> $stable(trans_o));
  assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(pass_o && fail_o));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  assert_done_after_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state) == S_FIN && !busy_o));
  assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && start_i && !rsp_vld_i) |=> ($stable(pat_o) && $stable(sig_o) && $stable(trans_o)));
endmodule

// File: tb/tb_sig_analyzer_bist.sv
`timescale 1ns/1ps
module tb_sig_analyzer_bist;
  localparam int NPAT = 20;
  localparam int NREF = 4;
  localparam int PW = $clog2(NPAT);
  localparam int NONE = 99;

  function automatic logic rsp_of(input int p, input logic [7:0] m, input int flt);
    logic [7:0] pv;
    pv = 8'(p);
    return (^(pv & m)) ^ (p == flt);
  endfunction

  function automatic logic [15:0] model_sig(input logic [7:0] m, input int flt);
    logic [15:0] s;
    s = '0;
    for (int p = 0; p < NPAT; p++)
      s = {s[14:0], s[15] ^ s[11] ^ s[8] ^ s[6] ^ rsp_of(p, m, flt)};
    return s;
  endfunction

  function automatic int model_trans(input logic [7:0] m, input int flt);
    int n;
    n = 0;
    for (int p = 1; p < NPAT; p++)
      if (rsp_of(p, m, flt) != rsp_of(p - 1, m, flt)) n++;
    return n;
  endfunction

  localparam logic [15:0] G0 = model_sig(8'h01, NONE);
  localparam logic [15:0] G1 = model_sig(8'h13, NONE);
  localparam logic [15:0] G2 = model_sig(8'h2C, NONE);
  localparam logic [15:0] G3 = 16'hBEEF;
  localparam logic [16*NREF-1:0] GTAB = {G3, G2, G1, G0};

  // mask, sel, fault index, gap cycles, mid-run start
  typedef struct packed {
    logic [7:0] mask;
    logic [1:0] sel;
    logic [7:0] flt;
    logic [1:0] gap;
    logic       inj;
  } vec_t;
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 2'd0, 8'd99, 2'd0, 1'b0},
    '{8'h13, 2'd1, 8'd99, 2'd1, 1'b1},
    '{8'h13, 2'd1, 8'd7,  2'd0, 1'b0},
    '{8'h2C, 2'd2, 8'd99, 2'd2, 1'b1},
    '{8'h01, 2'd3, 8'd99, 2'd0, 1'b0},
    '{8'h00, 2'd0, 8'd99, 2'd1, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, rbit = 0, rvld = 0;
  logic [1:0] rsel = 0, dsel = 0;
  logic [PW-1:0] pat, trans;
  logic busy, done, pass, fail;
  logic [15:0] sig;
  logic [3:0] digit;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sig_analyzer_bist #(.NUM_PAT(NPAT), .NUM_REF(NREF), .GOLD_TAB(GTAB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ref_sel_i(rsel), .rsp_bit_i(rbit),
    .rsp_vld_i(rvld), .digit_sel_i(dsel), .pat_o(pat), .busy_o(busy), .done_o(done),
    .pass_o(pass), .fail_o(fail), .sig_o(sig), .trans_o(trans), .digit_o(digit));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] es;
    int et;
    logic ep;
    es = model_sig(v.mask, int'(v.flt));
    et = model_trans(v.mask, int'(v.flt));
    ep = (es == GTAB[16*v.sel +: 16]);
    start = 1; rsel = v.sel;
    @(negedge clk);
    start = 0; rsel = ~v.sel;
    chk("R1 busy after start", busy, 1);
    chk("R1 pattern zero", pat, 0);
    chk("R4 sig cleared", sig, 0);
    chk("R3 trans cleared", trans, 0);
    chk("R8 verdict cleared", {pass, fail}, 0);
    for (int i = 0; i < NPAT; i++) begin
      for (int g = 0; g < v.gap; g++) begin
        rvld = 0; start = v.inj;
        @(negedge clk);
        start = 0;
      end
      chk("R2 pattern order", pat, i);
      rvld = 1; rbit = rsp_of(i, v.mask, int'(v.flt));
      start = v.inj && (i == 5);
      @(negedge clk);
      start = 0;
    end
    rvld = 0;
    chk("R7 no early done", done, 0);
    chk("R7 busy before done", busy, 1);
    @(negedge clk);
    chk("R7 done pulse", done, 1);
    chk("R7 busy drop", busy, 0);
    chk("R4 signature", sig, es);
    chk("R3 transitions", trans, et);
    chk("R6 pass", pass, ep);
    chk("R6 fail", fail, !ep);
    for (int d = 0; d < 4; d++) begin
      dsel = 2'(d);
      #0.1;
      chk("R5 digit", digit, es[15 - 4*d -: 4]);
    end
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R8 pass held", pass, ep);
    chk("R8 fail held", fail, !ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset verdict", {pass, fail}, 0);
    chk("R10 reset pat", pat, 0);
    chk("R10 reset sig", sig, 0);
    chk("R10 reset trans", trans, 0);
    rst_n = 1;
    @(negedge clk);
    foreach (VECS[k]) run_vec(VECS[k]);
    // R9 directed: a start held high for a whole run changes nothing
    start = 1; rsel = 0;
    @(negedge clk);
    for (int i = 0; i < NPAT; i++) begin
      chk("R9 start ignored pattern", pat, i);
      rvld = 1; rbit = rsp_of(i, 8'h01, NONE);
      @(negedge clk);
    end
    rvld = 0; start = 0;
    @(negedge clk);
    chk("R9 start ignored signature", sig, G0);
    chk("R9 start ignored verdict", pass, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule